// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block cleans up one asynchronous GPIO input before the pin-status and interrupt logic see it. The raw pad level is brought into the core clock domain through a short synchronizer chain. It then passes through a filter whose behaviour is set by a 2-bit mode, a 4-bit step count and two timebase-select bits. The slow timebase arrives as a one-cycle `rtc_tick` enable, one pulse per reference-clock period (nominally 32.768 kHz). A prescaler turns those ticks into filter steps of 2, 8, 512 or 2048 ticks, so the programmable window runs from tens of microseconds up to about one second.

There are four modes. One passes the level straight through. One rejects short pulses of either polarity. The last two are asymmetric: a pulse of one polarity reaches the output at once, and a move to the other level has to stay stable for the whole window. A fixed-setting override lets a global configuration bit replace the per-pin settings with settings built in at design time. This serves the one pin whose filtering is owned by internal logic.

Top module: `gpio_debounce_filter`

## Requirements
- R1: With mode 0 (bypass) the output follows the synchronized pad level, changing on the 3rd rising clock edge after the pad changes, whatever the count and timebase bits hold.
- R2: Timebase select {long_range, unit_sel} gives a filter step every 2 ticks for {0,0}, 8 for {0,1}, 512 for {1,0} and 2048 for {1,1}. With a tick every cycle, a filtered transition shows on edge 2 + N*D after the pad change, where N is the step count and D the step length.
- R3: Mode 3 (filter both) changes the output only after the synchronized level has differed from it for N*D consecutive ticked cycles. A pulse of either polarity that lasts fewer pad cycles is dropped, and any reversion restarts the count from zero.
- R4: Mode 1 (keep low) passes a falling input to the output on the 3rd edge, even for a one-cycle low pulse. A rising input is filtered as in R3.
- R5: Mode 2 (keep high) passes a rising input on the 3rd edge, even for a one-cycle high pulse. A falling input is filtered as in R3, so short low pulses are dropped.
- R6: A step count of 0 in modes 1 to 3 acts as a count of 1.
- R7: Any change of the effective mode, count or timebase bits clears the pending count and loads the current synchronized level into the output on the next edge.
- R8: While `force_fixed` is high (and the override is built in), the built-in settings (default: mode 3, count 3, timebase {0,0}) are used and changes on the per-pin configuration inputs have no effect.
- R9: The filter advances only on cycles with `rtc_tick` high. With the tick held low a pending transition never completes.
- R10: A synchronous active-low reset drives the output, synchronizer and counters to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rtc_tick | input | 1 | One-cycle enable per slow reference clock period |
| pad_raw | input | 1 | Asynchronous pad level |
| mode_sel | input | 2 | 0 bypass, 1 keep low, 2 keep high, 3 filter both |
| step_count | input | 4 | Number of steps in the window (0 acts as 1) |
| unit_sel | input | 1 | Timebase select, lower bit |
| long_range | input | 1 | Timebase select, upper bit |
| force_fixed | input | 1 | Replace per-pin settings with built-in settings |
| level_out | output | 1 | Filtered level |

## Verification
Two events can land on the same edge. The first is the final filter step that would accept a new level. The second is the synchronized input falling back to the old level. The design decides on the level held before that edge, so the pulse is accepted. Two vector rows provoke this with filter-both pulses one cycle shorter than the window and exactly as long as it. The bench then checks that the shorter pulse is dropped and that the exact-length pulse changes the output on the edge where the reversion arrives. A second collision puts a configuration change on an edge while a transition is pending. The bench judges it by the output taking the new level one edge later rather than after the full window.

// File: rtl/gdbf_pkg.sv
// Shared types for the GPIO debounce filter.
// Assumes a 4-bit step count; the mode encoding is fixed by the register layout.
package gdbf_pkg;
    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        MODE_OFF       = 2'd0,
        MODE_KEEP_LOW  = 2'd1,
        MODE_KEEP_HIGH = 2'd2,
        MODE_FILTER    = 2'd3
    } flt_mode_e;

    typedef struct packed {
        flt_mode_e         mode;
        logic [CNT_W-1:0]  count;
        logic              unit_sel;
        logic              long_range;
    } flt_cfg_t;
endpackage

// File: rtl/gdbf_sync.sv
// Multi-flop synchronizer for the asynchronous pad level.
// Assumes STAGES >= 1; each stage is a plain flop that resets to 0.
module gdbf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Capture the raw level in the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= 1'b0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Shift the level one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= 1'b0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gdbf_prescale.sv
// Step generator: divides rtc ticks by 2^EXP_x, chosen by {long_range, unit_sel}.
// Runs only while a transition is pending (run high); otherwise its phase is cleared,
// so a window always starts on a full step. Assumes EXP_D is the largest exponent.
module gdbf_prescale #(
    parameter int EXP_A = 1,
    parameter int EXP_B = 3,
    parameter int EXP_C = 9,
    parameter int EXP_D = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic unit_sel,
    input  logic long_range,
    output logic step
);
    localparam int PW_AB = (EXP_A > EXP_B) ? EXP_A : EXP_B;
    localparam int PW_CD = (EXP_C > EXP_D) ? EXP_C : EXP_D;
    localparam int PW    = (PW_AB > PW_CD) ? PW_AB : PW_CD;
    localparam logic [PW-1:0] LAST_A = PW'((1 << EXP_A) - 1);
    localparam logic [PW-1:0] LAST_B = PW'((1 << EXP_B) - 1);
    localparam logic [PW-1:0] LAST_C = PW'((1 << EXP_C) - 1);
    localparam logic [PW-1:0] LAST_D = PW'((1 << EXP_D) - 1);

    logic [PW-1:0] phase;
    logic [PW-1:0] last;

    // Pick the terminal phase for the selected timebase.
    always_comb begin
        case ({long_range, unit_sel})
            2'b00:   last = LAST_A;
            2'b01:   last = LAST_B;
            2'b10:   last = LAST_C;
            default: last = LAST_D;
        endcase
    end

    assign step = run && tick && (phase == last);

    // Advance the phase on each tick while running; wrap at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase <= '0;
        else if (!run)      phase <= '0;
        else if (tick)      phase <= (phase == last) ? '0 : phase + 1'b1;
    end

    // R2: the phase never passes the terminal value of the current timebase.
    p_phase_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (phase <= last));

    // R2: steps are at least two cycles apart, since every timebase is 2 ticks or more.
    p_step_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (last != '0)) |=> !step);
endmodule

// File: rtl/gdbf_core.sv
// Filter state machine: holds the accepted level and counts steps of a pending change.
// Assumes reload is raised for one cycle whenever mode or count change, so the
// count register never has to cope with a shrinking limit.
module gdbf_core
    import gdbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  flt_mode_e        mode,
    input  logic [CNT_W-1:0] count,
    input  logic             step,
    input  logic             reload,
    output logic             q,
    output logic             hold_req
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_last;
    logic             pending;
    logic             fast_pass;

    // Decode the window length and which transitions skip the filter.
    always_comb begin
        cnt_last  = (count == '0) ? '0 : count - 1'b1;
        pending   = (lvl != q);
        fast_pass = ((mode == MODE_KEEP_LOW)  && !lvl) ||
                    ((mode == MODE_KEEP_HIGH) &&  lvl);
        hold_req  = pending && (mode != MODE_OFF) && !fast_pass;
    end

    // Update the accepted level and the step count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            cnt <= '0;
        end else if (reload || (mode == MODE_OFF)) begin
            q   <= lvl;
            cnt <= '0;
        end else if (!pending) begin
            cnt <= '0;
        end else if (fast_pass) begin
            q   <= lvl;
            cnt <= '0;
        end else if (step) begin
            if (cnt == cnt_last) begin
                q   <= lvl;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R1: bypass copies the synchronized level one edge later.
    p_bypass_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_OFF) && !reload) |=> (q == $past(lvl)));

    // R3: in filter-both mode the level moves only on a step or a reload.
    p_filter_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_FILTER) && !step && !reload) |=> $stable(q));

    // R4: a falling level passes at once in keep-low mode.
    p_fast_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_KEEP_LOW) && !lvl && q && !reload) |=> !q);

    // R5: a rising level passes at once in keep-high mode.
    p_fast_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_KEEP_HIGH) && lvl && !q && !reload) |=> q);

    // R6: the count stays inside the window (count 0 allows only one step).
    p_cnt_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |-> (cnt <= cnt_last));
endmodule

// File: rtl/gpio_debounce_filter.sv
// Top of the GPIO debounce filter: synchronizer, configuration select with the
// fixed-setting override, change detection, step prescaler and filter core.
// Assumes the configuration inputs are quasi-static and in the clk domain.
module gpio_debounce_filter
    import gdbf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EXP_A       = 1,
    parameter int EXP_B       = 3,
    parameter int EXP_C       = 9,
    parameter int EXP_D       = 11,
    parameter bit FIXED_EN    = 1'b1,
    parameter int FIXED_MODE  = 3,
    parameter int FIXED_COUNT = 3,
    parameter bit FIXED_UNIT  = 1'b0,
    parameter bit FIXED_LONG  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rtc_tick,
    input  logic       pad_raw,
    input  logic [1:0] mode_sel,
    input  logic [3:0] step_count,
    input  logic       unit_sel,
    input  logic       long_range,
    input  logic       force_fixed,
    output logic       level_out
);
    localparam flt_cfg_t FIX_CFG = '{
        mode:       flt_mode_e'(2'(FIXED_MODE)),
        count:      CNT_W'(FIXED_COUNT),
        unit_sel:   FIXED_UNIT,
        long_range: FIXED_LONG
    };

    logic     lvl_sync;
    flt_cfg_t pin_cfg;
    flt_cfg_t eff_cfg;
    flt_cfg_t prev_cfg;
    logic     reload;
    logic     hold_req;
    logic     step;

    gdbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_raw),
        .q     (lvl_sync)
    );

    // Choose the per-pin or built-in settings and flag any change of them.
    always_comb begin
        pin_cfg = '{
            mode:       flt_mode_e'(mode_sel),
            count:      step_count,
            unit_sel:   unit_sel,
            long_range: long_range
        };
        eff_cfg = (FIXED_EN && force_fixed) ? FIX_CFG : pin_cfg;
        reload  = (eff_cfg != prev_cfg);
    end

    // Remember the settings in force to detect the next change.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_cfg <= '0;
        else        prev_cfg <= eff_cfg;
    end

    gdbf_prescale #(
        .EXP_A (EXP_A),
        .EXP_B (EXP_B),
        .EXP_C (EXP_C),
        .EXP_D (EXP_D)
    ) u_prescale (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (rtc_tick),
        .run        (hold_req && !reload),
        .unit_sel   (eff_cfg.unit_sel),
        .long_range (eff_cfg.long_range),
        .step       (step)
    );

    gdbf_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_sync),
        .mode     (eff_cfg.mode),
        .count    (eff_cfg.count),
        .step     (step),
        .reload   (reload),
        .q        (level_out),
        .hold_req (hold_req)
    );

    // R7: a settings change loads the synchronized level on the next edge.
    p_reload_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (level_out == $past(lvl_sync)));

    // R9: without a tick no step can be produced.
    p_no_tick_no_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rtc_tick |-> !step);
endmodule

// File: tb/gpio_debounce_filter_test.sv
module gpio_debounce_filter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_tick = 1'b1;
    logic       pad_raw = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [3:0] step_count = 4'd0;
    logic       unit_sel = 1'b0;
    logic       long_range = 1'b0;
    logic       force_fixed = 1'b0;
    logic       level_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gpio_debounce_filter uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rtc_tick    (rtc_tick),
        .pad_raw     (pad_raw),
        .mode_sel    (mode_sel),
        .step_count  (step_count),
        .unit_sel    (unit_sel),
        .long_range  (long_range),
        .force_fixed (force_fixed),
        .level_out   (level_out)
    );

    // mode, count, unit, long, start level, pulse cycles (0 = held), expected edge (0 = none)
    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  cnt;
        logic        u;
        logic        lg;
        logic        start;
        logic [7:0]  pulse;
        logic [15:0] lat;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd9,  1'b1, 1'b1, 1'b0, 8'd0, 16'd3},     // R1 bypass, settings ignored
        '{2'd3, 4'd3,  1'b0, 1'b0, 1'b0, 8'd0, 16'd8},     // R3 rise, 3 x 2
        '{2'd3, 4'd3,  1'b0, 1'b0, 1'b1, 8'd5, 16'd0},     // R3 low pulse one short
        '{2'd3, 4'd3,  1'b0, 1'b0, 1'b1, 8'd6, 16'd8},     // R3 pulse equal to window
        '{2'd3, 4'd0,  1'b0, 1'b0, 1'b0, 8'd0, 16'd4},     // R6 count 0 acts as 1
        '{2'd3, 4'd15, 1'b0, 1'b0, 1'b1, 8'd0, 16'd32},    // R3 largest count
        '{2'd3, 4'd3,  1'b1, 1'b0, 1'b0, 8'd0, 16'd26},    // R2 step of 8
        '{2'd3, 4'd1,  1'b0, 1'b1, 1'b1, 8'd0, 16'd514},   // R2 step of 512
        '{2'd3, 4'd2,  1'b1, 1'b1, 1'b0, 8'd0, 16'd4098},  // R2 step of 2048
        '{2'd1, 4'd4,  1'b0, 1'b0, 1'b1, 8'd1, 16'd3},     // R4 one-cycle low passes
        '{2'd1, 4'd4,  1'b0, 1'b0, 1'b0, 8'd0, 16'd10},    // R4 rise filtered
        '{2'd2, 4'd4,  1'b0, 1'b0, 1'b0, 8'd1, 16'd3},     // R5 one-cycle high passes
        '{2'd2, 4'd4,  1'b0, 1'b0, 1'b1, 8'd0, 16'd10},    // R5 fall filtered
        '{2'd2, 4'd2,  1'b0, 1'b0, 1'b1, 8'd3, 16'd0}      // R5 short low dropped
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bring the output to a known level through bypass mode.
    task automatic settle(input logic lvl);
        @(negedge clk);
        force_fixed = 1'b0;
        mode_sel = 2'd0; step_count = 4'd0; unit_sel = 1'b0; long_range = 1'b0;
        pad_raw = lvl;
        repeat (6) @(negedge clk);
    endtask

    // Count edges from a pad change until the output moves; 0 if it never does.
    task automatic measure(input logic start, input int pulse, input int lim, output int lat);
        int n = 0;
        bit moved = 1'b0;
        pad_raw = ~start;
        while (!moved && n < lim) begin
            @(posedge clk);
            n++;
            #1;
            if (level_out !== start) moved = 1'b1;
            else if (pulse != 0 && n == pulse) pad_raw = start;
        end
        lat = moved ? n : 0;
    endtask

    initial begin
        int lat;
        // R10: reset holds the output low even with the pad high.
        pad_raw = 1'b1;
        repeat (4) @(posedge clk);
        #1 chk("R10 reset output", level_out, 0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            settle(VECS[i].start);
            mode_sel = VECS[i].mode; step_count = VECS[i].cnt;
            unit_sel = VECS[i].u; long_range = VECS[i].lg;
            repeat (3) @(negedge clk);
            measure(VECS[i].start, int'(VECS[i].pulse), 5000, lat);
            chk($sformatf("vector %0d latency (R1..R6 per row)", i), lat, int'(VECS[i].lat));
        end

        // R8: override uses built-in filter (count 3, step 2); per-pin change ignored.
        settle(1'b0);
        force_fixed = 1'b1;
        repeat (3) @(negedge clk);
        begin
            int n = 0;
            bit moved = 1'b0;
            pad_raw = 1'b1;
            while (!moved && n < 100) begin
                @(posedge clk);
                n++;
                #1;
                if (level_out !== 1'b0) moved = 1'b1;
                else if (n == 4) begin
                    mode_sel = 2'd3; step_count = 4'd0;
                end
            end
            chk("R8 override latency", moved ? n : 0, 8);
        end

        // R9: no tick, no progress; then the window runs once ticks resume.
        settle(1'b0);
        rtc_tick = 1'b0;
        mode_sel = 2'd3; step_count = 4'd1;
        repeat (3) @(negedge clk);
        pad_raw = 1'b1;
        repeat (50) @(posedge clk);
        #1 chk("R9 held without tick", level_out, 0);
        @(negedge clk) rtc_tick = 1'b1;
        @(posedge clk);
        #1 chk("R9 first tick", level_out, 0);
        @(posedge clk);
        #1 chk("R9 second tick", level_out, 1);

        // R7: a settings change mid-window loads the level on the next edge.
        settle(1'b0);
        mode_sel = 2'd3; step_count = 4'd15; unit_sel = 1'b1; long_range = 1'b1;
        repeat (3) @(negedge clk);
        pad_raw = 1'b1;
        repeat (10) @(posedge clk);
        #1 chk("R7 pending before change", level_out, 0);
        @(negedge clk) step_count = 4'd14;
        @(posedge clk);
        #1 chk("R7 loaded after change", level_out, 1);

        // R10: reset during operation clears the output.
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 chk("R10 reset clears output", level_out, 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule